// File: doc/BRIEF.md
# Keypad Status Register with Opposing-Direction Masking

This block turns a set of ten raw, active-low push-button lines into a byte-readable status register. Each line passes through a two-flop synchronizer. A masking stage then makes sure the direction pad never reports two opposing directions held at the same moment. When both buttons of an opposing pair are down, both bits read as released.

Software sees the result through a small request/response port. A request carries a byte offset and a write flag. Offset 0x130 returns buttons 0 to 7. Offset 0x131 returns buttons 8 and 9 in its lowest two bits. Every other offset reads as zero. Writes are accepted and answered, but they change nothing.

The port follows valid/ready rules on both channels:
- A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- Its response appears on the following edge with `rsp_valid` high.
- While a response waits with `rsp_ready` low, the response stays frozen and `req_ready` stays low. The response therefore acts as the single point of back-pressure.

Top module: `keypad_status`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1. With no button held, offset 0x130 reads 0xFF and offset 0x131 reads 0x03.
- R2: Register bits are active-low: 1 means released and 0 means held. Offset 0x130 carries `key_raw_n[7:0]` in bits 7..0.
- R3: Offset 0x131 carries `key_raw_n[9:8]` in bits 1..0, and its bits 7..2 always read 0.
- R4: When bits 6 and 7 (the vertical direction pair) would both read 0, both read 1 instead.
- R5: When bits 4 and 5 (the horizontal direction pair) would both read 0, both read 1 instead.
- R6: A single held button of a pair reads 0. Masking one pair leaves the other pair and the remaining bits unchanged.
- R7: After a change on `key_raw_n`, a read accepted on the first or second rising edge returns the old value. A read accepted on the third rising edge returns the new value.
- R8: A read of any offset other than 0x130 or 0x131 returns 0x00.
- R9: A write to any offset is accepted and answered with data 0x00. A write leaves all later read values unchanged.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_data` hold their values and `req_ready` is 0.
- R11: A request accepted on an edge produces `rsp_valid` = 1 after that same edge. Back-to-back requests are accepted every cycle while `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_raw_n | input | 10 | Raw button lines, 0 = held, asynchronous to clk |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write (ignored), 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| rsp_valid | output | 1 | Response data present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Response byte |

## Verification
The bench builds the block with its default parameters: ten keys, two synchronizer stages and a 12-bit offset. With these values the full two-byte map is reachable, including the six always-zero bits of the upper byte. The two-edge synchronizer window is short enough that a single request stream held across a button change sees the old, old, new sequence. Button patterns mix held pairs, lone directions and both pairs at once. Responses are also held back to exercise the hold rule.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  localparam int BYTE_W = 8;

  // Opposing direction pairs: each entry names the lower bit of a pair,
  // the partner is the next bit up. Order does not matter.
  localparam int PAIR_COUNT = 2;
  localparam int PAIR_BASE [PAIR_COUNT] = '{4, 6};

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } byte_sel_e;

endpackage

// File: rtl/keypad_sync.sv
module keypad_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '1;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/keypad_conflict_mask.sv
module keypad_conflict_mask
  import keypad_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] held_n,
  output logic [WIDTH-1:0] shown_n
);

  always_comb begin
    shown_n = held_n;
    for (int p = 0; p < PAIR_COUNT; p++) begin
      if (!held_n[PAIR_BASE[p]] && !held_n[PAIR_BASE[p] + 1]) begin
        shown_n[PAIR_BASE[p]]     = 1'b1;
        shown_n[PAIR_BASE[p] + 1] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/keypad_rsp_port.sv
module keypad_rsp_port
  import keypad_pkg::*;
#(
  parameter int              WIDTH     = 10,
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] LO_OFFSET = 12'h130,
  parameter logic [ADDR_W-1:0] HI_OFFSET = 12'h131
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  status_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data
);

  localparam int HI_W  = WIDTH - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W;

  byte_sel_e         sel;
  logic [BYTE_W-1:0] byte_next;
  logic              take;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_comb begin
    sel = SEL_NONE;
    if (!req_write) begin
      if (req_addr == LO_OFFSET)      sel = SEL_LO;
      else if (req_addr == HI_OFFSET) sel = SEL_HI;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_LO:  byte_next = status_n[BYTE_W-1:0];
      SEL_HI:  byte_next = {{PAD_W{1'b0}}, status_n[WIDTH-1:BYTE_W]};
      default: byte_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= byte_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r10_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r11_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r8_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write &&
     req_addr != LO_OFFSET && req_addr != HI_OFFSET) |=> (rsp_data == '0));

  a_r9_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (rsp_data == '0));

  a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == HI_OFFSET)
      |=> (rsp_data[BYTE_W-1:HI_W] == '0));

endmodule

// File: rtl/keypad_status.sv
module keypad_status
  import keypad_pkg::*;
#(
  parameter int                NUM_KEYS    = 10,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] LO_OFFSET   = 12'h130,
  parameter logic [ADDR_W-1:0] HI_OFFSET   = 12'h131
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] key_raw_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [7:0]          rsp_data
);

  logic [NUM_KEYS-1:0] held_n;
  logic [NUM_KEYS-1:0] shown_n;

  keypad_sync #(
    .WIDTH  (NUM_KEYS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (key_raw_n),
    .sync_out (held_n)
  );

  keypad_conflict_mask #(
    .WIDTH (NUM_KEYS)
  ) u_mask (
    .held_n  (held_n),
    .shown_n (shown_n)
  );

  keypad_rsp_port #(
    .WIDTH     (NUM_KEYS),
    .ADDR_W    (ADDR_W),
    .LO_OFFSET (LO_OFFSET),
    .HI_OFFSET (HI_OFFSET)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_n  (shown_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  a_r4_vertical_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(!shown_n[6] && !shown_n[7]));

  a_r5_horizontal_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(!shown_n[4] && !shown_n[5]));

  a_r6_lone_vertical_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (held_n[7] != held_n[6]) |-> (shown_n[7:6] == held_n[7:6]));

  a_r6_lone_horizontal_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (held_n[5] != held_n[4]) |-> (shown_n[5:4] == held_n[5:4]));

endmodule

// File: tb/keypad_status_tb.sv
module keypad_status_tb;

  localparam logic [11:0] LO = 12'h130;
  localparam logic [11:0] HI = 12'h131;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  key_raw_n = '1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  keypad_status u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_raw_n (key_raw_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  function automatic logic [7:0] model(input logic [9:0] k, input logic [11:0] a,
                                       input logic wr);
    logic [7:0] v;
    v = 8'h00;
    if (!wr && a == LO) begin
      v = k[7:0];
      if (v[7:6] == 2'b00) v[7:6] = 2'b11;
      if (v[5:4] == 2'b00) v[5:4] = 2'b11;
    end else if (!wr && a == HI) begin
      v = {6'b0, k[9:8]};
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input logic [9:0] k);
    @(posedge clk); #1;
    key_raw_n = k;
    repeat (4) @(posedge clk);
  endtask

  task automatic issue(input logic [11:0] a, input logic wr, input string tag);
    exp_q.push_back(model(key_raw_n, a, wr));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_write = wr;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // monitor: pops one expectation per completed response handshake
  always @(negedge clk) begin : monitor
    logic [7:0] e;
    string t;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rsp_data, e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid after reset", {7'b0, rsp_valid}, 8'h00);
    check("R1 req_ready after reset", {7'b0, req_ready}, 8'h01);
    issue(LO, 1'b0, "R1 low byte idle");
    issue(HI, 1'b0, "R1 high byte idle");

    // R2/R3 plain bit placement
    settle(10'b10_1111_1110);
    issue(LO, 1'b0, "R2 button0 held");
    issue(HI, 1'b0, "R3 button8 held");
    settle(10'b01_0101_1011);
    issue(LO, 1'b0, "R2 mixed pattern");
    issue(HI, 1'b0, "R3 button9 held");

    // R4/R5 pair masking
    settle(10'b01_0011_0101);
    issue(LO, 1'b0, "R4 vertical pair both held");
    settle(10'b11_1100_1010);
    issue(LO, 1'b0, "R5 horizontal pair both held");
    settle(10'b00_0000_0000);
    issue(LO, 1'b0, "R4 R5 every button held");
    issue(HI, 1'b0, "R3 upper bits zero all held");

    // R6 lone directions
    settle(10'b11_1011_1111);
    issue(LO, 1'b0, "R6 lone up");
    settle(10'b11_1101_1111);
    issue(LO, 1'b0, "R6 lone left");
    settle(10'b11_1000_1111);
    issue(LO, 1'b0, "R6 lone vertical beside masked horizontal");
    settle(10'b11_0111_0000);
    issue(LO, 1'b0, "R6 lone down beside free horizontal");

    // R8 other offsets
    issue(12'h132, 1'b0, "R8 offset 0x132");
    issue(12'h12F, 1'b0, "R8 offset 0x12F");
    issue(12'h000, 1'b0, "R8 offset 0x000");

    // R9 writes
    settle(10'b10_0110_1100);
    issue(LO, 1'b1, "R9 write low offset");
    issue(HI, 1'b1, "R9 write high offset");
    issue(LO, 1'b0, "R9 low byte after writes");
    issue(HI, 1'b0, "R9 high byte after writes");

    // R7 synchronizer latency with a back-to-back request stream (R11)
    settle(10'b11_1111_1111);
    @(posedge clk); #1;
    exp_q.push_back(8'hFF); tag_q.push_back("R7 first edge old value");
    exp_q.push_back(8'hFF); tag_q.push_back("R7 second edge old value");
    exp_q.push_back(8'hE7); tag_q.push_back("R7 third edge new value");
    key_raw_n = 10'b11_1110_0111;
    req_valid = 1'b1; req_addr = LO; req_write = 1'b0;
    repeat (3) @(posedge clk);
    #1 req_valid = 1'b0;
    repeat (2) @(posedge clk);

    // R10/R11 back-pressure
    settle(10'b01_1110_1101);
    @(posedge clk); #1 rsp_ready = 1'b0;
    issue(LO, 1'b0, "R10 stalled response data");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 R10 rsp_valid held", {7'b0, rsp_valid}, 8'h01);
      check("R10 req_ready low while stalled", {7'b0, req_ready}, 8'h00);
      check("R10 data held while stalled", rsp_data, 8'hED);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 rsp_valid drops after handshake", {7'b0, rsp_valid}, 8'h00);

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11 responses missing actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule